// File: doc/BRIEF.md
# RTC Alarm Match and Interrupt

This block sits beside the time counters of a real-time clock. Once per second it compares the running BCD calendar (seconds, minutes, hours, day of month, month) with five programmable alarm bytes. A five-bit repeat code says which of those fields may be ignored. When the comparison succeeds, an alarm flag is latched. If interrupts are enabled, the block asks for an active-low, open-drain interrupt pin to be pulled down. Software clears the flag by reading the flag register.

Software reaches the block through a small register port that works by pointer. A pointer load selects an address. Every read or write then acts on the address the pointer holds, and the pointer moves up by one afterwards. A power-mode input adds a further enable for the interrupt while the system runs from its back-up supply.

Top module: `rtc_alarm_unit`

## Requirements
- R1: The repeat code {RPT5..RPT1} is taken from bit 7 of the alarm bytes: month at address 1 (RPT5), date at address 2, hour at address 3, minute at address 4, seconds at address 5 (RPT1). A bit at 1 drops its field from the comparison. The accepted codes are 11111 (every second), 11110 (minute), 11100 (hour), 11000 (day), 10000 (month) and 00000 (year).
- R2: Any repeat code outside the accepted set behaves as 11111, so the alarm fires every second.
- R3: The alarm flag AF (bit 6 of the flag register at address 6) is set only on a cycle with `tickSec` high whose compared fields all match. Without a tick it stays unchanged.
- R4: In normal power mode, `irqPullLow` is 1 exactly when AF and AFE (bit 0 at address 0) are both set and the pointer is not on address 6. It follows AF from the clock edge that sets AF.
- R5: While the pointer holds address 6, `irqPullLow` stays 0 even if AF is set. This includes the pointer arriving there after a write to address 5. Moving the pointer elsewhere lets the pending alarm assert.
- R6: A read of address 6 returns the current AF in the same cycle. AF is 0 from the next edge, so the interrupt is released and a second read returns 0.
- R7: With `battMode` high, the interrupt additionally needs ABE (bit 1 at address 0).
- R8: Reset clears AFE, ABE, AF and all alarm bytes. An alarm matched before AFE is written sets AF only and leaves `irqPullLow` at 0.
- R9: Zero written to all five alarm bytes (date 0, code 00000) disables the alarm. No valid date then gives a match.
- R10: A tick with a match in the same cycle as a flag read leaves AF set.
- R11: `ptrLoad` loads `ptrVal` into the pointer. Each read or write without a load advances the pointer by one, and it wraps from 7 to 0.
- R12: Readback keeps bit 7 plus the field bits: 7 bits for seconds and minutes, 6 bits for hour and date, 5 bits for month. Address 0 reads back bits 1:0. Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous power-up reset |
| tickSec | input | 1 | One-cycle strobe each second from the time counter |
| curSec | input | 8 | Current seconds, BCD |
| curMin | input | 8 | Current minutes, BCD |
| curHour | input | 8 | Current hours, BCD |
| curDate | input | 8 | Current day of month, BCD |
| curMonth | input | 8 | Current month, BCD |
| battMode | input | 1 | 1 while running from back-up supply |
| ptrLoad | input | 1 | Load register pointer |
| ptrVal | input | 3 | Pointer value to load |
| wrEn | input | 1 | Write at pointer, then advance |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read at pointer, then advance |
| rdData | output | 8 | Data at current pointer (combinational) |
| irqPullLow | output | 1 | 1 pulls the interrupt pin low, 0 releases it |

## Verification
AF and `irqPullLow` change at the rising edge that samples `tickSec`. The bench therefore drives the tick for one cycle and looks at the interrupt on the following falling edge. `rdData` is combinational on the pointer and is sampled during the read cycle itself, before the edge that clears AF. The effect of the clear is checked either at the next falling edge (interrupt) or by a second read. Pointer changes act on the interrupt from the edge that loads or advances the pointer, so hold and release are checked one falling edge after each pointer operation.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_FIELDS = 5;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int CTRL_ADDR  = 0;
  localparam int FLAG_ADDR  = 6;
  localparam int RPT_BIT    = 7;
  localparam int AF_BIT     = 6;
  localparam int AFE_BIT    = 0;
  localparam int ABE_BIT    = 1;

  // field 0 = seconds ... field 4 = month
  function automatic int fieldWidth(input int f);
    case (f)
      0, 1:    return 7;
      2, 3:    return 6;
      default: return 5;
    endcase
  endfunction

  // seconds byte sits just below the flag address, month lowest
  function automatic int fieldAddr(input int f);
    return FLAG_ADDR - 1 - f;
  endfunction

  function automatic logic [NUM_FIELDS-1:0] effRepeat(input logic [NUM_FIELDS-1:0] code);
    case (code)
      5'b11111, 5'b11110, 5'b11100,
      5'b11000, 5'b10000, 5'b00000: return code;
      default:                      return '1;
    endcase
  endfunction

  typedef struct packed {
    logic [FLAG_ADDR-1:0] wrSel;
    logic                 rdFlag;
    logic                 tick;
  } strobe_t;
endpackage

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ptrLoad,
  input  logic [ADDR_W-1:0] ptrVal,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              tickSec,
  input  logic              battMode,
  input  logic              afFlag,
  input  logic              afeBit,
  input  logic              abeBit,
  output strobe_t           stb,
  output logic [ADDR_W-1:0] ptr,
  output logic              irqPullLow
);
  logic onFlag;
  logic powerOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ptr <= '0;
    else if (ptrLoad)       ptr <= ptrVal;
    else if (wrEn || rdEn)  ptr <= ptr + 1'b1;
  end

  assign onFlag  = (ptr == ADDR_W'(FLAG_ADDR));
  assign powerOk = !battMode || abeBit;

  always_comb begin
    stb.wrSel = '0;
    for (int a = 0; a < FLAG_ADDR; a++)
      stb.wrSel[a] = wrEn && (ptr == ADDR_W'(a));
    stb.rdFlag = rdEn && onFlag;
    stb.tick   = tickSec;
  end

  assign irqPullLow = afFlag && afeBit && powerOk && !onFlag;

  assert_ptr_step_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!ptrLoad && (wrEn || rdEn)) |=> (ptr == $past(ptr) + 1'b1));

  assert_ptr_load_R11: assert property (@(posedge clk) disable iff (!rstN)
    ptrLoad |=> (ptr == $past(ptrVal)));

  assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqPullLow |-> afFlag);
endmodule

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  strobe_t                            stb,
  input  logic [DATA_W-1:0]                  wrData,
  input  logic [NUM_FIELDS-1:0][DATA_W-1:0]  curTime,
  input  logic [ADDR_W-1:0]                  ptr,
  output logic [DATA_W-1:0]                  rdData,
  output logic                               afFlag,
  output logic                               afeBit,
  output logic                               abeBit
);
  logic [NUM_FIELDS-1:0][DATA_W-1:0] almAll;
  logic [NUM_FIELDS-1:0]             ignoreRaw;
  logic [NUM_FIELDS-1:0]             fieldEq;
  logic [NUM_FIELDS-1:0]             ignoreEff;
  logic                              matchNow;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : gField
    localparam int W = fieldWidth(f);
    localparam int A = fieldAddr(f);
    localparam logic [DATA_W-1:0] VMASK = DATA_W'((1 << W) - 1);
    localparam logic [DATA_W-1:0] KEEP  = VMASK | (DATA_W'(1) << RPT_BIT);
    logic [DATA_W-1:0] almQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              almQ <= '0;
      else if (stb.wrSel[A])  almQ <= wrData & KEEP;
    end

    assign almAll[f]    = almQ;
    assign ignoreRaw[f] = almQ[RPT_BIT];
    assign fieldEq[f]   = ((almQ ^ curTime[f]) & VMASK) == '0;
  end

  assign ignoreEff = effRepeat(ignoreRaw);
  assign matchNow  = &(fieldEq | ignoreEff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      afeBit <= 1'b0;
      abeBit <= 1'b0;
    end else if (stb.wrSel[CTRL_ADDR]) begin
      afeBit <= wrData[AFE_BIT];
      abeBit <= wrData[ABE_BIT];
    end
  end

  // a match on the tick wins over a clearing read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       afFlag <= 1'b0;
    else if (stb.tick && matchNow)   afFlag <= 1'b1;
    else if (stb.rdFlag)             afFlag <= 1'b0;
  end

  always_comb begin
    rdData = '0;
    if (ptr == ADDR_W'(CTRL_ADDR)) begin
      rdData[AFE_BIT] = afeBit;
      rdData[ABE_BIT] = abeBit;
    end else if (ptr == ADDR_W'(FLAG_ADDR)) begin
      rdData[AF_BIT] = afFlag;
    end else begin
      for (int f = 0; f < NUM_FIELDS; f++)
        if (ptr == ADDR_W'(fieldAddr(f))) rdData = almAll[f];
    end
  end

  assert_af_rise_on_tick_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(afFlag) |-> $past(stb.tick));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdFlag && !stb.tick) |=> !afFlag);

  assert_match_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tick && matchNow) |=> afFlag);
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickSec,
  input  logic [DATA_W-1:0] curSec,
  input  logic [DATA_W-1:0] curMin,
  input  logic [DATA_W-1:0] curHour,
  input  logic [DATA_W-1:0] curDate,
  input  logic [DATA_W-1:0] curMonth,
  input  logic              battMode,
  input  logic              ptrLoad,
  input  logic [ADDR_W-1:0] ptrVal,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              irqPullLow
);
  strobe_t                           stb;
  logic [ADDR_W-1:0]                 ptr;
  logic                              afFlag;
  logic                              afeBit;
  logic                              abeBit;
  logic [NUM_FIELDS-1:0][DATA_W-1:0] curTime;

  assign curTime = {curMonth, curDate, curHour, curMin, curSec};

  rtc_alarm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ptrLoad(ptrLoad), .ptrVal(ptrVal),
    .wrEn(wrEn), .rdEn(rdEn), .tickSec(tickSec), .battMode(battMode),
    .afFlag(afFlag), .afeBit(afeBit), .abeBit(abeBit),
    .stb(stb), .ptr(ptr), .irqPullLow(irqPullLow)
  );

  rtc_alarm_dp uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .curTime(curTime),
    .ptr(ptr), .rdData(rdData), .afFlag(afFlag), .afeBit(afeBit), .abeBit(abeBit)
  );
endmodule

// File: tb/rtc_alarm_unit_test.sv
`timescale 1ns/1ps
module rtc_alarm_unit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickSec = 1'b0;
  logic [7:0] curSec = '0, curMin = '0, curHour = '0, curDate = '0, curMonth = '0;
  logic       battMode = 1'b0;
  logic       ptrLoad = 1'b0;
  logic [2:0] ptrVal = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       irqPullLow;

  int  nChk = 0;
  int  nBad = 0;
  bit  done = 1'b0;
  logic [7:0] almVal [5] = '{8'h45, 8'h30, 8'h12, 8'h15, 8'h07};

  always #5 clk = ~clk;

  rtc_alarm_unit uut (
    .clk(clk), .rstN(rstN), .tickSec(tickSec), .curSec(curSec), .curMin(curMin),
    .curHour(curHour), .curDate(curDate), .curMonth(curMonth), .battMode(battMode),
    .ptrLoad(ptrLoad), .ptrVal(ptrVal), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .irqPullLow(irqPullLow)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic setPtr(input int a);
    ptrLoad = 1'b1; ptrVal = 3'(a);
    cyc();
    ptrLoad = 1'b0;
  endtask

  task automatic wrReg(input int a, input logic [7:0] d);
    setPtr(a);
    wrEn = 1'b1; wrData = d;
    cyc();
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input int a, output logic [7:0] d);
    setPtr(a);
    rdEn = 1'b1;
    #1 d = rdData;
    cyc();
    rdEn = 1'b0;
  endtask

  task automatic pulseTick();
    tickSec = 1'b1;
    cyc();
    tickSec = 1'b0;
  endtask

  task automatic setTime(input int v);
    curSec   = almVal[0] ^ ((v == 1) ? 8'h01 : 8'h00);
    curMin   = almVal[1] ^ ((v == 2) ? 8'h01 : 8'h00);
    curHour  = almVal[2] ^ ((v == 3) ? 8'h01 : 8'h00);
    curDate  = almVal[3] ^ ((v == 4) ? 8'h01 : 8'h00);
    curMonth = almVal[4] ^ ((v == 5) ? 8'h01 : 8'h00);
  endtask

  function automatic logic [4:0] expRepeat(input logic [4:0] c);
    if (c == 5'b11111 || c == 5'b11110 || c == 5'b11100 ||
        c == 5'b11000 || c == 5'b10000 || c == 5'b00000) return c;
    return 5'b11111;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R8: reset state
    chk("R8 irq after reset", {7'b0, irqPullLow}, 8'h00);
    rdReg(0, d); chk("R8 enables after reset", d, 8'h00);
    rdReg(6, d); chk("R8 flag after reset", d, 8'h00);
    rdReg(5, d); chk("R8 alarm seconds after reset", d, 8'h00);

    // R8: alarm before AFE sets AF only
    for (int a = 1; a <= 5; a++) wrReg(a, 8'h80);
    setPtr(0);
    pulseTick();
    chk("R8 irq stays released without AFE", {7'b0, irqPullLow}, 8'h00);
    rdReg(6, d); chk("R8 AF set without AFE", d, 8'h40);

    wrReg(0, 8'h01);

    // R1 R2: sweep all 32 repeat codes against single-field mismatches
    for (int c = 0; c < 32; c++) begin
      logic [4:0] code;
      logic [4:0] eff;
      code = 5'(c);
      eff  = expRepeat(code);
      for (int f = 0; f < 5; f++) wrReg(5 - f, almVal[f] | {code[f], 7'b0});
      setPtr(0);
      for (int v = 0; v < 6; v++) begin
        logic hit;
        hit = (v == 0) || eff[(v == 0) ? 0 : v - 1];
        setTime(v);
        pulseTick();
        chk((eff == code) ? "R1 R4 irq for listed code" : "R2 irq for unlisted code",
            {7'b0, irqPullLow}, {7'b0, hit});
        rdReg(6, d);
        chk((eff == code) ? "R1 R3 AF for listed code" : "R2 AF for unlisted code",
            d, hit ? 8'h40 : 8'h00);
      end
    end

    // R5: pointer lands on flag address after write to alarm seconds
    for (int a = 1; a <= 5; a++) wrReg(a, 8'h80);
    pulseTick();
    chk("R5 irq held on flag address", {7'b0, irqPullLow}, 8'h00);
    setPtr(0);
    chk("R5 irq after pointer moves", {7'b0, irqPullLow}, 8'h01);

    // R6: clearing read returns 1, next read 0
    rdReg(6, d); chk("R6 clearing read still shows AF", d, 8'h40);
    chk("R6 irq released after read", {7'b0, irqPullLow}, 8'h00);
    rdReg(6, d); chk("R6 second read shows cleared AF", d, 8'h00);

    // R3: no tick, no flag
    repeat (3) cyc();
    rdReg(6, d); chk("R3 AF unchanged without tick", d, 8'h00);

    // R7: back-up mode needs ABE
    battMode = 1'b1;
    wrReg(0, 8'h01);
    pulseTick();
    chk("R7 irq blocked without ABE", {7'b0, irqPullLow}, 8'h00);
    wrReg(0, 8'h03);
    chk("R7 irq with ABE and AFE", {7'b0, irqPullLow}, 8'h01);
    battMode = 1'b0;
    rdReg(6, d); chk("R6 clear after back-up alarm", d, 8'h40);

    // R10: match and flag read in the same cycle
    setPtr(6);
    rdEn = 1'b1; tickSec = 1'b1;
    #1 d = rdData;
    chk("R10 read data before simultaneous set", d, 8'h00);
    cyc();
    rdEn = 1'b0; tickSec = 1'b0;
    rdReg(6, d); chk("R10 AF survives simultaneous read", d, 8'h40);

    // R12: flag write ignored, readback masks
    pulseTick();
    wrReg(6, 8'h00);
    rdReg(6, d); chk("R12 flag write ignored", d, 8'h40);
    wrReg(7, 8'hFF);
    rdReg(0, d); chk("R12 address 7 write ignored", d, 8'h03);
    wrReg(1, 8'hFF); rdReg(1, d); chk("R12 month readback mask", d, 8'h9F);
    wrReg(3, 8'hFF); rdReg(3, d); chk("R12 hour readback mask", d, 8'hBF);
    wrReg(4, 8'hFF); rdReg(4, d); chk("R12 minute readback mask", d, 8'hFF);
    wrReg(0, 8'hFE); rdReg(0, d); chk("R12 enable readback mask", d, 8'h02);

    // R11: auto-increment and wrap
    setPtr(2);
    wrEn = 1'b1; wrData = 8'h11;
    cyc();
    wrData = 8'h22;
    cyc();
    wrEn = 1'b0;
    rdReg(2, d); chk("R11 first write in burst", d, 8'h11);
    rdReg(3, d); chk("R11 second write in burst", d, 8'h22);
    setPtr(7);
    rdEn = 1'b1;
    cyc();
    #1 d = rdData;
    chk("R11 pointer wraps to 0", d, 8'h02);
    cyc();
    rdEn = 1'b0;

    // R9: all-zero alarm disables
    wrReg(0, 8'h01);
    for (int a = 1; a <= 5; a++) wrReg(a, 8'h00);
    setPtr(0);
    rdReg(6, d);
    for (int v = 0; v < 3; v++) begin
      setTime(0);
      if (v == 1) begin
        curSec = 8'h00; curMin = 8'h00; curHour = 8'h00; curDate = 8'h01; curMonth = 8'h01;
      end
      if (v == 2) curDate = 8'h31;
      pulseTick();
      chk("R9 irq with disabled alarm", {7'b0, irqPullLow}, 8'h00);
      rdReg(6, d); chk("R9 AF with disabled alarm", d, 8'h00);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule